// File: doc/BRIEF.md
# Configurable PLD Macrocell Chain

This block is a slice of programmable-logic fabric: a row of macrocells sharing one global input bus. Each macrocell owns five product terms, each an AND over a chosen set of true or inverted literals. Every product term is routed by a small per-term code into one of three places: the macrocell's OR sum, a dedicated special use tied to its index, or nowhere.

The OR sum of one macrocell can pull in the running sum of its lower neighbour, so a chain of eight macrocells forms one sum of up to forty terms. A polarity/toggle XOR stage follows the sum. It can act as a plain inverter, a product-term XOR, a T flip-flop or a JK flip-flop. A register with a choice of data source comes next, and an output select picks either the registered or the combinational value.

One term per macrocell may drive a foldback line. The other macrocells' terms can use that line as a literal. The whole configuration is a static vector. It is captured while reset is held low and then frozen.

Top module: `pld_chain`

## Requirements
- R1: With W = N_GLB + 2*N_MC and slice size S = 10*W + 18, term k (0..4) of macrocell m takes its true mask from cfg bits [m*S + 2*k*W +: W] and its inverted mask from [m*S + 2*k*W + W +: W]. The literal vector holds glb_i in bits below N_GLB, the register outputs in the next N_MC bits and the foldback lines in the top N_MC bits. A term is the AND of its selected literals, and it is 1 when no literal is selected. Term 4 sees the foldback positions as constant 0.
- R2: The 2-bit route code of term k sits at m*S + 10*W + 2*k. Code 1 sends the term to the sum, and code 2 gives it its special use. Codes 0 and 3 force the term inactive, so it affects no sum, output or control.
- R3: The local sum of a macrocell is the OR of its terms with route code 1.
- R4: The link bit at m*S + 10*W + 10 makes the sum of macrocell m equal its local sum OR the full sum of macrocell m-1. Macrocell 0 takes nothing from below. Eight linked macrocells therefore OR forty terms.
- R5: The 3-bit XOR mode at m*S + 10*W + 11 sets the combinational value. Mode 0 passes the sum. Mode 1 inverts it. Mode 2 XORs it with special term 0. Modes 5 to 7 act as mode 0.
- R6: Mode 3 gives the register T behaviour: the combinational value is sum XOR register. Mode 4 gives JK behaviour, with J the sum and K special term 0, so the combinational value is the register XOR ((J AND NOT Q) OR (K AND Q)).
- R7: The 2-bit data select at m*S + 10*W + 14 picks the register input. Codes 0 and 3 take the combinational value, code 1 takes special term 1, and code 2 takes pin_i[m].
- R8: When special term 2 is 1, the register clears on the next edge, and this overrides every other input. If term 3 has route code 2, the register loads only when that term is 1. Otherwise it loads on every edge.
- R9: Foldback line m equals term 4 when that term has route code 2, and 0 otherwise. All macrocells see it in the same cycle.
- R10: The output select bit at m*S + 10*W + 16 drives mc_out_o[m] from the register (0) or the combinational value (1). mc_vld_o[m] follows the bit at m*S + 10*W + 17.
- R11: cfg_i is captured only on edges where rst_n is low and is ignored at all other times. Reset clears every register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also opens configuration capture |
| cfg_i | input | N_MC*(10*(N_GLB+2*N_MC)+18) | Static configuration vector |
| glb_i | input | N_GLB | Global input bus |
| pin_i | input | N_MC | Per-macrocell pin input, one register data source |
| mc_out_o | output | N_MC | Selected macrocell outputs |
| mc_vld_o | output | N_MC | Per-macrocell output-valid flags |

## Verification
The bench builds the chain with eight macrocells and a six-bit global bus. Eight stages are enough for the forty-term linked sum to be driven end to end. The narrow global bus makes sparse random terms evaluate true often enough for cascades, toggles and JK updates to change state. Directed configurations then reach each route, XOR mode, data source and control term, and foldback lines feed further terms.

// File: rtl/pld_chain_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings and configuration field offsets for the macrocell chain.
// Assumes all offsets are relative to the start of one macrocell's slice.
package pld_chain_pkg;

    typedef enum logic [1:0] {
        ROUTE_NONE  = 2'd0,
        ROUTE_SUM   = 2'd1,
        ROUTE_SPEC  = 2'd2,
        ROUTE_NONE2 = 2'd3
    } route_e;

    typedef enum logic [2:0] {
        XM_PASS   = 3'd0,
        XM_INVERT = 3'd1,
        XM_PTERM  = 3'd2,
        XM_TOGGLE = 3'd3,
        XM_JK     = 3'd4
    } xmode_e;

    typedef enum logic [1:0] {
        DS_XOR  = 2'd0,
        DS_TERM = 2'd1,
        DS_PIN  = 2'd2,
        DS_XOR2 = 2'd3
    } dsel_e;

    localparam int TERMS_PER_MC = 5;

    // literal bus width for a given fabric size
    function automatic int bus_width(input int n_glb, input int n_mc);
        return n_glb + 2 * n_mc;
    endfunction

    // offsets of the control fields inside one slice
    function automatic int route_off(input int w);
        return 2 * TERMS_PER_MC * w;
    endfunction

    function automatic int link_off(input int w);
        return route_off(w) + 2 * TERMS_PER_MC;
    endfunction

    function automatic int xmode_off(input int w);
        return link_off(w) + 1;
    endfunction

    function automatic int dsel_off(input int w);
        return xmode_off(w) + 3;
    endfunction

    function automatic int osel_off(input int w);
        return dsel_off(w) + 2;
    endfunction

    function automatic int oe_off(input int w);
        return osel_off(w) + 1;
    endfunction

    function automatic int slice_width(input int w);
        return oe_off(w) + 1;
    endfunction

endpackage

// File: rtl/pld_pterm.sv
`timescale 1ns/1ps
// Module: one programmable product term.
// ANDs every literal selected in true form and every literal selected in
// inverted form; an empty selection yields 1. A low enable forces 0.
module pld_pterm #(
    parameter int W = 8
) (
    input  logic [W-1:0] lit_i,
    input  logic [W-1:0] tmask_i,
    input  logic [W-1:0] cmask_i,
    input  logic         en_i,
    output logic         term_o
);

    logic [W-1:0] ok;

    // each literal position passes unless its selected polarity is violated
    always_comb begin
        for (int j = 0; j < W; j++) begin
            ok[j] = (~tmask_i[j] | lit_i[j]) & (~cmask_i[j] | ~lit_i[j]);
        end
    end

    assign term_o = en_i & (&ok);

endmodule

// File: rtl/pld_term_bank.sv
`timescale 1ns/1ps
// Module: a group of product terms with their route decoders.
// Terms with a sum route feed the OR; terms with a special route are
// presented individually; any other route disables the term.
module pld_term_bank
    import pld_chain_pkg::*;
#(
    parameter int NT = 4,
    parameter int W  = 8
) (
    input  logic [W-1:0]    lit_i,
    input  logic [NT*W-1:0] tmask_i,
    input  logic [NT*W-1:0] cmask_i,
    input  logic [2*NT-1:0] route_i,
    output logic            sum_o,
    output logic [NT-1:0]   spec_o
);

    logic [NT-1:0] val;
    logic [NT-1:0] to_sum;

    for (genvar k = 0; k < NT; k++) begin : g_term
        route_e rt;
        logic   on;

        assign rt = route_e'(route_i[2*k +: 2]);
        assign on = (rt == ROUTE_SUM) || (rt == ROUTE_SPEC);

        pld_pterm #(.W(W)) i_pterm (
            .lit_i   (lit_i),
            .tmask_i (tmask_i[k*W +: W]),
            .cmask_i (cmask_i[k*W +: W]),
            .en_i    (on),
            .term_o  (val[k])
        );

        assign to_sum[k] = val[k] & (rt == ROUTE_SUM);
        assign spec_o[k] = val[k] & (rt == ROUTE_SPEC);
    end

    assign sum_o = |to_sum;

endmodule

// File: rtl/pld_cascade.sv
`timescale 1ns/1ps
// Module: the sum chain across neighbouring macrocells.
// Each stage ORs its local sum with the full sum of the stage below when its
// link bit is set; stage 0 sees a constant 0 from below.
module pld_cascade #(
    parameter int N = 8
) (
    input  logic [N-1:0] local_i,
    input  logic [N-1:0] link_i,
    output logic [N-1:0] total_o
);

    // ripple the running sum upward through the linked stages
    always_comb begin : p_chain
        logic carry;
        carry = 1'b0;
        for (int i = 0; i < N; i++) begin
            total_o[i] = local_i[i] | (link_i[i] & carry);
            carry      = total_o[i];
        end
    end

endmodule

// File: rtl/pld_mc_reg.sv
`timescale 1ns/1ps
// Module: XOR stage, register and output select of one macrocell.
// Assumes special-term inputs are already 0 when the term is not routed
// to its special use, and that ena_i is 1 when no enable term is routed.
module pld_mc_reg
    import pld_chain_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sum_i,
    input  logic       xpt_i,
    input  logic       dpt_i,
    input  logic       clr_i,
    input  logic       ena_i,
    input  logic       pin_i,
    input  logic [2:0] xmode_i,
    input  logic [1:0] dsel_i,
    input  logic       osel_i,
    output logic       q_o,
    output logic       out_o
);

    logic q;
    logic comb;
    logic d;
    logic jk_t;

    // second XOR operand and polarity / toggle behaviour
    always_comb begin
        jk_t = (sum_i & ~q) | (xpt_i & q);
        case (xmode_e'(xmode_i))
            XM_INVERT: comb = ~sum_i;
            XM_PTERM:  comb = sum_i ^ xpt_i;
            XM_TOGGLE: comb = sum_i ^ q;
            XM_JK:     comb = q ^ jk_t;
            default:   comb = sum_i;
        endcase
    end

    // register data source choice
    always_comb begin
        case (dsel_e'(dsel_i))
            DS_TERM: d = dpt_i;
            DS_PIN:  d = pin_i;
            default: d = comb;
        endcase
    end

    // state register with clear priority and optional load enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (clr_i) begin
            q <= 1'b0;
        end else if (ena_i) begin
            q <= d;
        end
    end

    assign q_o   = q;
    assign out_o = osel_i ? comb : q;

endmodule

// File: rtl/pld_chain.sv
`timescale 1ns/1ps
// Module: top of the macrocell chain.
// Captures the configuration while reset is low, builds the shared literal
// bus from the global inputs, register outputs and foldback lines, and
// wires term banks, the cascade and the per-macrocell registers.
// Assumes cfg_i is stable during the reset cycles that capture it.
module pld_chain
    import pld_chain_pkg::*;
#(
    parameter  int N_GLB   = 8,
    parameter  int N_MC    = 8,
    localparam int BUS_W   = bus_width(N_GLB, N_MC),
    localparam int SLICE_W = slice_width(BUS_W),
    localparam int CFG_W   = N_MC * SLICE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [N_GLB-1:0] glb_i,
    input  logic [N_MC-1:0]  pin_i,
    output logic [N_MC-1:0]  mc_out_o,
    output logic [N_MC-1:0]  mc_vld_o
);

    localparam int RT_OFF = route_off(BUS_W);
    localparam int LK_OFF = link_off(BUS_W);
    localparam int XM_OFF = xmode_off(BUS_W);
    localparam int DS_OFF = dsel_off(BUS_W);
    localparam int OS_OFF = osel_off(BUS_W);
    localparam int OE_OFF = oe_off(BUS_W);
    localparam int RT_W   = 2 * TERMS_PER_MC;

    logic [CFG_W-1:0]     cfg_q;
    logic [N_MC-1:0]      q_bus;
    logic [N_MC-1:0]      fold_bus;
    logic [N_MC-1:0]      sum_loc;
    logic [N_MC-1:0]      sum_tot;
    logic [N_MC-1:0]      clr_vec;
    logic [N_MC-1:0]      ena_vec;
    logic [N_MC-1:0]      link_vec;
    logic [N_MC-1:0]      os_vec;
    logic [RT_W*N_MC-1:0] rt_vec;
    logic [3*N_MC-1:0]    xm_vec;
    logic [2*N_MC-1:0]    ds_vec;
    logic [BUS_W-1:0]     lit_full;
    logic [BUS_W-1:0]     lit_fold;

    // configuration is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= cfg_i;
        end
    end

    assign lit_full = {fold_bus, q_bus, glb_i};
    assign lit_fold = {{N_MC{1'b0}}, q_bus, glb_i};

    for (genvar m = 0; m < N_MC; m++) begin : g_fields
        assign rt_vec[m*RT_W +: RT_W] = cfg_q[m*SLICE_W + RT_OFF +: RT_W];
        assign link_vec[m]            = cfg_q[m*SLICE_W + LK_OFF];
        assign xm_vec[3*m +: 3]       = cfg_q[m*SLICE_W + XM_OFF +: 3];
        assign ds_vec[2*m +: 2]       = cfg_q[m*SLICE_W + DS_OFF +: 2];
        assign os_vec[m]              = cfg_q[m*SLICE_W + OS_OFF];
        assign mc_vld_o[m]            = cfg_q[m*SLICE_W + OE_OFF];
    end

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        logic [4*BUS_W-1:0] tm_lo;
        logic [4*BUS_W-1:0] cm_lo;
        logic [3:0]         spec_lo;
        logic [0:0]         spec_f;
        logic               sum_lo;
        logic               sum_f;

        for (genvar k = 0; k < 4; k++) begin : g_mask
            assign tm_lo[k*BUS_W +: BUS_W] = cfg_q[m*SLICE_W + 2*k*BUS_W +: BUS_W];
            assign cm_lo[k*BUS_W +: BUS_W] = cfg_q[m*SLICE_W + 2*k*BUS_W + BUS_W +: BUS_W];
        end

        pld_term_bank #(.NT(4), .W(BUS_W)) i_bank (
            .lit_i   (lit_full),
            .tmask_i (tm_lo),
            .cmask_i (cm_lo),
            .route_i (rt_vec[m*RT_W +: 8]),
            .sum_o   (sum_lo),
            .spec_o  (spec_lo)
        );

        pld_term_bank #(.NT(1), .W(BUS_W)) i_fold (
            .lit_i   (lit_fold),
            .tmask_i (cfg_q[m*SLICE_W + 8*BUS_W +: BUS_W]),
            .cmask_i (cfg_q[m*SLICE_W + 9*BUS_W +: BUS_W]),
            .route_i (rt_vec[m*RT_W + 8 +: 2]),
            .sum_o   (sum_f),
            .spec_o  (spec_f)
        );

        assign fold_bus[m] = spec_f[0];
        assign sum_loc[m]  = sum_lo | sum_f;
        assign clr_vec[m]  = spec_lo[2];
        assign ena_vec[m]  = (route_e'(rt_vec[m*RT_W + 6 +: 2]) == ROUTE_SPEC) ? spec_lo[3] : 1'b1;

        pld_mc_reg i_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .sum_i   (sum_tot[m]),
            .xpt_i   (spec_lo[0]),
            .dpt_i   (spec_lo[1]),
            .clr_i   (clr_vec[m]),
            .ena_i   (ena_vec[m]),
            .pin_i   (pin_i[m]),
            .xmode_i (xm_vec[3*m +: 3]),
            .dsel_i  (ds_vec[2*m +: 2]),
            .osel_i  (os_vec[m]),
            .q_o     (q_bus[m]),
            .out_o   (mc_out_o[m])
        );
    end

    pld_cascade #(.N(N_MC)) i_cascade (
        .local_i (sum_loc),
        .link_i  (link_vec),
        .total_o (sum_tot)
    );

endmodule

// File: rtl/pld_chain_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound to pld_chain.
// Relates configuration state, sums, foldback lines and register updates.
module pld_chain_chk
    import pld_chain_pkg::*;
#(
    parameter  int N_GLB   = 8,
    parameter  int N_MC    = 8,
    localparam int BUS_W   = bus_width(N_GLB, N_MC),
    localparam int SLICE_W = slice_width(BUS_W),
    localparam int CFG_W   = N_MC * SLICE_W,
    localparam int RT_W    = 2 * TERMS_PER_MC
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CFG_W-1:0]     cfg_q,
    input logic [N_MC-1:0]      q_bus,
    input logic [N_MC-1:0]      fold_bus,
    input logic [N_MC-1:0]      sum_loc,
    input logic [N_MC-1:0]      sum_tot,
    input logic [N_MC-1:0]      clr_vec,
    input logic [N_MC-1:0]      ena_vec,
    input logic [N_MC-1:0]      link_vec,
    input logic [RT_W*N_MC-1:0] rt_vec,
    input logic [3*N_MC-1:0]    xm_vec,
    input logic [2*N_MC-1:0]    ds_vec,
    input logic [N_MC-1:0]      pin_i
);

    logic [N_MC-1:0] fold_ok;
    logic [N_MC-1:0] link_eff;

    for (genvar m = 0; m < N_MC; m++) begin : g_dec
        assign fold_ok[m]  = (route_e'(rt_vec[m*RT_W + 8 +: 2]) == ROUTE_SPEC);
        assign link_eff[m] = (m != 0) && link_vec[m];
    end

    // R11: first cycle out of reset starts from cleared registers
    assert_reset_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(!rst_n)) |-> (q_bus == '0));

    // R11: configuration cannot move while running
    assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q));

    // R8: an active clear term empties the register on the next edge
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((q_bus & $past(clr_vec)) == '0));

    // R4: the chained sum never drops a local term
    assert_sum_cover_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((sum_loc & ~sum_tot) == '0));

    // R4: unlinked stages carry only their own sum
    assert_unlinked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (((~link_eff) & (sum_tot ^ sum_loc)) == '0));

    // R9: a foldback line is quiet unless its term is routed there
    assert_fold_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((fold_bus & ~fold_ok) == '0));

    for (genvar m = 0; m < N_MC; m++) begin : g_seq
        logic tog;
        logic pin_load;

        assign tog      = (xmode_e'(xm_vec[3*m +: 3]) == XM_TOGGLE)
                        && (dsel_e'(ds_vec[2*m +: 2]) == DS_XOR);
        assign pin_load = (dsel_e'(ds_vec[2*m +: 2]) == DS_PIN);

        // R6: toggle mode flips the register when the sum is high
        assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (tog && !clr_vec[m] && ena_vec[m]) |=> (q_bus[m] == ($past(q_bus[m]) ^ $past(sum_tot[m]))));

        // R7: pin source loads the pin value
        assert_pin_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_load && !clr_vec[m] && ena_vec[m]) |=> (q_bus[m] == $past(pin_i[m])));

        // R8: a low enable term holds the register
        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!ena_vec[m] && !clr_vec[m]) |=> $stable(q_bus[m]));
    end

endmodule

bind pld_chain pld_chain_chk #(.N_GLB(N_GLB), .N_MC(N_MC)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_q    (cfg_q),
    .q_bus    (q_bus),
    .fold_bus (fold_bus),
    .sum_loc  (sum_loc),
    .sum_tot  (sum_tot),
    .clr_vec  (clr_vec),
    .ena_vec  (ena_vec),
    .link_vec (link_vec),
    .rt_vec   (rt_vec),
    .xm_vec   (xm_vec),
    .ds_vec   (ds_vec),
    .pin_i    (pin_i)
);

// File: tb/test_pld_chain.sv
`timescale 1ns/1ps
// Bench: scoreboard for pld_chain. The driver loads configurations, drives
// random inputs, and queues the outputs a behavioural model predicts; the
// monitor pops each item and compares it with the design.
module test_pld_chain;

    localparam int N_GLB = 6;
    localparam int N_MC  = 8;
    localparam int W     = N_GLB + 2 * N_MC;
    localparam int SW    = 10 * W + 18;
    localparam int CW    = N_MC * SW;
    localparam int RT    = 10 * W;
    localparam int LK    = RT + 10;
    localparam int XM    = RT + 11;
    localparam int DS    = RT + 14;
    localparam int OS    = RT + 16;
    localparam int OE    = RT + 17;

    typedef struct {
        logic [N_MC-1:0] out;
        logic [N_MC-1:0] vld;
        string           tag;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [CW-1:0]   cfg = '0;
    logic [N_GLB-1:0] glb = '0;
    logic [N_MC-1:0] pin = '0;
    logic [N_MC-1:0] mc_out;
    logic [N_MC-1:0] mc_vld;

    logic [CW-1:0]   m_cfg;
    logic [CW-1:0]   cfg_build;
    logic [N_MC-1:0] m_q;
    item_t           sb[$];
    int              checks = 0;
    int              errors = 0;
    bit              done = 1'b0;

    pld_chain #(.N_GLB(N_GLB), .N_MC(N_MC)) i_pld_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_i    (cfg),
        .glb_i    (glb),
        .pin_i    (pin),
        .mc_out_o (mc_out),
        .mc_vld_o (mc_vld)
    );

    always #10 clk = ~clk;

    function automatic int fld(input int m, input int off, input int w);
        int v = 0;
        for (int b = 0; b < w; b++) v |= int'(m_cfg[m*SW + off + b]) << b;
        return v;
    endfunction

    task automatic put(input int m, input int off, input int w, input int v);
        for (int b = 0; b < w; b++) cfg_build[m*SW + off + b] = v[b];
    endtask

    function automatic logic term_val(input int m, input int k, input logic [W-1:0] lit);
        int base = m*SW + 2*k*W;
        int r = fld(m, RT + 2*k, 2);
        if (r != 1 && r != 2) return 1'b0;
        for (int j = 0; j < W; j++) begin
            if (m_cfg[base + j] && !lit[j]) return 1'b0;
            if (m_cfg[base + W + j] && lit[j]) return 1'b0;
        end
        return 1'b1;
    endfunction

    // behavioural reference for one cycle: outputs now and register next
    task automatic model_eval(input logic [N_GLB-1:0] g, input logic [N_MC-1:0] p,
                              output logic [N_MC-1:0] o, output logic [N_MC-1:0] nq);
        logic [W-1:0]    lit;
        logic [N_MC-1:0] fold, loc, tot;
        logic            tv [N_MC][5];
        logic            prev, sp0, comb, d, ena, q;
        lit = {{N_MC{1'b0}}, m_q, g};
        for (int m = 0; m < N_MC; m++) begin
            tv[m][4] = term_val(m, 4, lit);
            fold[m]  = tv[m][4] && fld(m, RT + 8, 2) == 2;
        end
        lit = {fold, m_q, g};
        for (int m = 0; m < N_MC; m++)
            for (int k = 0; k < 4; k++) tv[m][k] = term_val(m, k, lit);
        prev = 1'b0;
        for (int m = 0; m < N_MC; m++) begin
            loc[m] = 1'b0;
            for (int k = 0; k < 5; k++) if (tv[m][k] && fld(m, RT + 2*k, 2) == 1) loc[m] = 1'b1;
            tot[m] = loc[m] | (m > 0 && fld(m, LK, 1) == 1 && prev);
            prev = tot[m];
        end
        for (int m = 0; m < N_MC; m++) begin
            q   = m_q[m];
            sp0 = tv[m][0] && fld(m, RT, 2) == 2;
            case (fld(m, XM, 3))
                1: comb = ~tot[m];
                2: comb = tot[m] ^ sp0;
                3: comb = tot[m] ^ q;
                4: comb = q ? ~sp0 : tot[m];
                default: comb = tot[m];
            endcase
            case (fld(m, DS, 2))
                1: d = tv[m][1] && fld(m, RT + 2, 2) == 2;
                2: d = p[m];
                default: d = comb;
            endcase
            ena = (fld(m, RT + 6, 2) == 2) ? tv[m][3] : 1'b1;
            if (tv[m][2] && fld(m, RT + 4, 2) == 2) nq[m] = 1'b0;
            else if (ena) nq[m] = d;
            else nq[m] = q;
            o[m] = (fld(m, OS, 1) == 1) ? comb : q;
        end
    endtask

    task automatic gen_random();
        cfg_build = '0;
        for (int m = 0; m < N_MC; m++) begin
            for (int k = 0; k < 5; k++) begin
                for (int j = 0; j < W; j++) begin
                    int r = $urandom % 16;
                    if (r == 0) cfg_build[m*SW + 2*k*W + j] = 1'b1;
                    else if (r == 1) cfg_build[m*SW + 2*k*W + W + j] = 1'b1;
                end
                put(m, RT + 2*k, 2, $urandom % 4);
            end
            put(m, LK, 1, $urandom % 2);
            put(m, XM, 3, $urandom % 6);
            put(m, DS, 2, $urandom % 4);
            put(m, OS, 1, $urandom % 2);
            put(m, OE, 1, $urandom % 2);
        end
    endtask

    // load cfg_build under reset, scramble cfg, then run and queue predictions
    task automatic run_phase(input string tag, input int cycles);
        logic [N_MC-1:0] eo, nq;
        item_t it;
        @(negedge clk);
        rst_n = 1'b0;
        cfg   = cfg_build;
        m_cfg = cfg_build;
        m_q   = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < CW; i++) cfg[i] = 1'($urandom % 2);
        for (int c = 0; c < cycles; c++) begin
            glb = N_GLB'($urandom);
            pin = N_MC'($urandom);
            #2;
            model_eval(glb, pin, eo, nq);
            it.out = eo;
            it.vld = '0;
            for (int m = 0; m < N_MC; m++) it.vld[m] = fld(m, OE, 1) == 1;
            it.tag = (c == 0) ? "R11" : tag;
            sb.push_back(it);
            @(posedge clk);
            #1;
            m_q = nq;
            @(negedge clk);
        end
    endtask

    // monitor: compare queued predictions mid-cycle
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #5;
            while (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (mc_out !== it.out) begin
                    errors++;
                    $display("FAIL %s mc_out actual=%b expected=%b", it.tag, mc_out, it.out);
                end
                checks++;
                if (mc_vld !== it.vld) begin
                    errors++;
                    $display("FAIL R10 mc_vld actual=%b expected=%b", mc_vld, it.vld);
                end
            end
        end
    end

    // watchdog ends a hung run as a failure
    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10 R2: every term off, pass mode, register outputs: all zero
        cfg_build = '0;
        run_phase("R2", 6);

        // R2 R5: random masks but every route off, inverted combinational output: all ones
        gen_random();
        for (int m = 0; m < N_MC; m++) begin
            for (int k = 0; k < 5; k++) put(m, RT + 2*k, 2, (k % 2) ? 3 : 0);
            put(m, XM, 3, 1);
            put(m, OS, 1, 1);
            put(m, OE, 1, 1);
        end
        run_phase("R2", 20);

        // R3 R4: every term a single literal in the sum, whole chain linked
        for (int rep = 0; rep < 3; rep++) begin
            cfg_build = '0;
            for (int m = 0; m < N_MC; m++) begin
                for (int k = 0; k < 5; k++) begin
                    cfg_build[m*SW + 2*k*W + ($urandom % N_GLB)] = 1'b1;
                    cfg_build[m*SW + 2*k*W + W + ($urandom % N_GLB)] = 1'b1;
                    put(m, RT + 2*k, 2, 1);
                end
                put(m, LK, 1, (rep == 2) ? (m % 2) : 1);
                put(m, OS, 1, 1);
            end
            run_phase("R4", 25);
        end

        // R5: product-term XOR operand
        gen_random();
        for (int m = 0; m < N_MC; m++) begin
            put(m, XM, 3, 2); put(m, RT, 2, 2); put(m, OS, 1, 1);
        end
        run_phase("R5", 25);

        // R6: toggle register
        gen_random();
        for (int m = 0; m < N_MC; m++) begin
            put(m, XM, 3, 3); put(m, DS, 2, 0);
            put(m, RT + 4, 2, 1); put(m, RT + 6, 2, 1);
        end
        run_phase("R6", 30);

        // R6: JK register with term 0 as K
        gen_random();
        for (int m = 0; m < N_MC; m++) begin
            put(m, XM, 3, 4); put(m, DS, 2, 0); put(m, RT, 2, 2);
        end
        run_phase("R6", 30);

        // R7: pin and separate-term data sources
        gen_random();
        for (int m = 0; m < N_MC; m++) begin
            put(m, DS, 2, 2); put(m, RT + 4, 2, 0); put(m, RT + 6, 2, 0); put(m, OS, 1, 0);
        end
        run_phase("R7", 25);
        gen_random();
        for (int m = 0; m < N_MC; m++) begin
            put(m, DS, 2, 1); put(m, RT + 2, 2, 2); put(m, OS, 1, 0);
        end
        run_phase("R7", 25);

        // R8: clear and enable terms
        gen_random();
        for (int m = 0; m < N_MC; m++) begin
            put(m, RT + 4, 2, 2); put(m, RT + 6, 2, 2); put(m, DS, 2, 2);
        end
        run_phase("R8", 30);

        // R9: foldback terms feeding the other terms
        gen_random();
        for (int m = 0; m < N_MC; m++) begin
            put(m, RT + 8, 2, 2);
            for (int k = 0; k < 4; k++) begin
                put(m, RT + 2*k, 2, 1);
                if ($urandom % 2 == 1) cfg_build[m*SW + 2*k*W + N_GLB + N_MC + ($urandom % N_MC)] = 1'b1;
            end
            put(m, OS, 1, 1);
        end
        run_phase("R9", 25);

        // R1 R3 R5 R10: random configurations
        for (int rep = 0; rep < 30; rep++) begin
            gen_random();
            run_phase("R1", 25);
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule